// File: doc/BRIEF.md
# Memory-to-Stream DMA Read Channel

This block is a single-channel, register-programmed DMA engine. It reads a contiguous byte buffer through a word-wide memory read port and sends it out as one AXI4-Stream packet. Software first writes the buffer's byte address and then its byte count. The count write starts the transfer. The engine fetches the buffer in bursts whose beat count never exceeds a parameter. It drives a standard stream master with tdata, tkeep, tlast, tvalid and tready. It keeps two sticky flags, one for completion and one for error, and software clears each of them by writing ones to it.

Stream and memory data are the same width. Each burst is requested only when the internal holding buffer has room for every beat of that burst, so the memory side never has to stall. Byte addresses must be aligned to the data width, because the engine does not realign data. A soft-reset command returns the channel to idle in two cycles, and a status bit lets software see when that reset has finished.

Top module: `mm2s_dma`

## Requirements
- R1: After reset the status word at register offset 1 reads 9: bit 0 (idle) is 1, bit 1 (done flag) is 0, bit 2 (error flag) is 0 and bit 3 (reset finished) is 1. At the same time m_tvalid, mem_req, irq_done and irq_err are all 0.
- R2: Writing a nonzero count to offset 3, while the channel is idle and the address held at offset 2 is aligned, starts a transfer. The transfer emits ceil(count/NB) beats, where NB is the number of data bytes per beat. Beat i carries the memory word at byte address start + i*NB.
- R3: Writing a zero count has no effect. No flag is set, the channel stays idle, and no memory request or stream beat appears.
- R4: A nonzero count write while the low log2(NB) bits of the start address are not all 0 sets the error flag and starts nothing.
- R5: A nonzero count write while a transfer is running sets the error flag. The running transfer continues unchanged.
- R6: Every memory burst asks for between 1 and MAX_BURST beats. Successive bursts start at the previous burst's address plus its beats times NB. mem_req, mem_addr and mem_beats stay unchanged until mem_gnt is seen.
- R7: m_tlast is 1 on the final beat of each transfer and on no other beat.
- R8: tkeep has all bits set on every beat except the final one when r = count mod NB is nonzero. On that final beat only the low r bits are set.
- R9: While m_tvalid is 1 and m_tready is 0, m_tvalid, m_tdata, m_tkeep and m_tlast hold their values. No beat is lost or sent twice.
- R10: The handshake of the final beat sets the done flag, which is driven on irq_done, and the channel becomes idle. Writing 1 to status bit 1 clears the done flag, and writing 1 to bit 2 clears the error flag (irq_err). A flag set event in the same cycle wins over a clear.
- R11: Writing 1 to bit 0 of offset 0 starts a soft reset. In the next cycle the status reads 0 in bit 3. From the cycle after that, the status reads idle with both flags clear, bit 3 is 1 again, and m_tvalid is 0.
- R12: Only the low LEN_W bits of a count write are used, and the count register at offset 3 reads back that truncated value. The largest count, 2^LEN_W - 1, completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset (0 control, 1 status, 2 start address, 3 count) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Burst request, held until granted |
| mem_addr | output | ADDR_W | Burst start byte address |
| mem_beats | output | BURST_W | Beats in the requested burst |
| mem_gnt | input | 1 | Burst accepted |
| mem_rdata | input | DATA_W | Returned read word |
| mem_rvalid | input | 1 | mem_rdata valid this cycle |
| m_tdata | output | DATA_W | Stream data |
| m_tkeep | output | DATA_W/8 | Stream byte-valid mask |
| m_tlast | output | 1 | Final beat of the packet |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| irq_done | output | 1 | Completion flag |
| irq_err | output | 1 | Error flag |

## Verification
The assertions assume the memory port behaves as follows. It returns exactly mem_beats words for each grant, in ascending address order. It never raises mem_rvalid in the grant cycle, and never raises it when no granted beats are still owed. The assertions also assume that no soft reset arrives while granted words are still owed. The bench's memory model queues the words of a burst only when it grants that burst, and grants only after the previous queue has drained. It issues the soft reset only after the holding buffer has filled and the engine has stopped requesting, with the stream sink held not-ready.

// File: rtl/mm2s_pkg.sv
// Shared register offsets and status bit positions for the memory-to-stream DMA.
package mm2s_pkg;
    typedef enum logic [1:0] {
        RG_CTRL = 2'd0,
        RG_STAT = 2'd1,
        RG_SRC  = 2'd2,
        RG_LEN  = 2'd3
    } reg_sel_e;

    localparam int ST_IDLE  = 0;
    localparam int ST_DONE  = 1;
    localparam int ST_ERR   = 2;
    localparam int ST_RDONE = 3;
endpackage

// File: rtl/mm2s_regs.sv
// Register file: holds the start address and count, decides whether a count
// write starts a transfer or raises an error, keeps the write-one-to-clear
// flags and the one-cycle soft-reset pulse.
// Assumes: one register access port, reads have no side effects.
module mm2s_regs
    import mm2s_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 14,
    parameter int NB_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy,
    input  logic              done_evt,
    output logic              srst_q,
    output logic [ADDR_W-1:0] src_q,
    output logic [LEN_W-1:0]  len_wr,
    output logic              go,
    output logic              done_q,
    output logic              err_q
);
    logic [LEN_W-1:0] len_q;
    logic             wr_len, wr_stat, misal, bad;

    assign wr_len  = we && (reg_sel_e'(addr) == RG_LEN);
    assign wr_stat = we && (reg_sel_e'(addr) == RG_STAT);
    assign len_wr  = wdata[LEN_W-1:0];
    assign misal   = |src_q[NB_W-1:0];
    assign go      = wr_len && (|len_wr) && !busy && !misal && !srst_q;
    assign bad     = wr_len && (|len_wr) && !srst_q && (busy || misal);

    // Register state, soft-reset pulse and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q <= 1'b0;
            src_q  <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            srst_q <= we && (reg_sel_e'(addr) == RG_CTRL) && wdata[0];
            if (we && (reg_sel_e'(addr) == RG_SRC)) src_q <= wdata[ADDR_W-1:0];
            if (go) len_q <= len_wr;
            if (srst_q) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end else begin
                done_q <= done_evt || (done_q && !(wr_stat && wdata[ST_DONE]));
                err_q  <= bad || (err_q && !(wr_stat && wdata[ST_ERR]));
            end
        end
    end

    // Read-data selection.
    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            RG_STAT: begin
                rdata[ST_IDLE]  = !busy;
                rdata[ST_DONE]  = done_q;
                rdata[ST_ERR]   = err_q;
                rdata[ST_RDONE] = !srst_q;
            end
            RG_SRC:  rdata = 32'(src_q);
            RG_LEN:  rdata = 32'(len_q);
            default: rdata = '0;
        endcase
    end

    // R10: a clear request with no set event empties the done flag.
    p_w1c_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[ST_DONE] && !done_evt) |=> !done_q)
        else $error("done flag survived a clear");

    // R4: a misaligned start never launches a transfer.
    p_misal_nostart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_len && misal && !srst_q && (|len_wr)) |=> err_q)
        else $error("misaligned start did not flag an error");
endmodule

// File: rtl/mm2s_fifo.sv
// Holding buffer between the memory read port and the stream output.
// Assumes: the writer never pushes into a full buffer (the burst sequencer
// only asks for what fits).
module mm2s_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] ram [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) ram[wr_ptr] <= din;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign dout  = ram[rd_ptr];
    assign empty = (count == '0);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr) |-> (count < CNT_W'(DEPTH)))
        else $error("holding buffer overflow");

    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty)
        else $error("holding buffer underflow");
endmodule

// File: rtl/mm2s_burst.sv
// Burst sequencer: cuts the transfer into requests of at most MAX_BURST
// beats at increasing addresses, and issues each only when the holding
// buffer has room for the whole burst and the previous one has fully returned.
// Assumes: memory returns mem_beats words per grant, never in the grant cycle.
module mm2s_burst #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 14,
    parameter int NB_W      = 2,
    parameter int MAX_BURST = 16,
    parameter int BURST_W   = 5,
    parameter int CNT_W     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               go,
    input  logic [ADDR_W-1:0]  src,
    input  logic [LEN_W-1:0]   beats_total,
    input  logic [CNT_W-1:0]   fifo_cnt,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [BURST_W-1:0] mem_beats,
    input  logic               mem_gnt,
    input  logic               mem_rvalid,
    output logic               push
);
    logic [LEN_W-1:0]   req_left;
    logic [BURST_W-1:0] pend, this_burst;
    logic [ADDR_W-1:0]  nxt_addr;
    logic [CNT_W-1:0]   room;
    logic               issue;

    assign this_burst = (req_left > LEN_W'(MAX_BURST)) ? BURST_W'(MAX_BURST)
                                                       : req_left[BURST_W-1:0];
    assign room  = CNT_W'(MAX_BURST) - fifo_cnt;
    assign issue = !mem_req && (pend == '0) && (req_left != '0)
                   && (room >= CNT_W'(this_burst));
    assign push  = mem_rvalid && (pend != '0);

    // Request generation and remaining-beat bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            req_left  <= '0;
            nxt_addr  <= '0;
            mem_req   <= 1'b0;
            mem_addr  <= '0;
            mem_beats <= '0;
        end else if (go) begin
            req_left <= beats_total;
            nxt_addr <= src;
        end else if (issue) begin
            mem_req   <= 1'b1;
            mem_addr  <= nxt_addr;
            mem_beats <= this_burst;
        end else if (mem_req && mem_gnt) begin
            mem_req  <= 1'b0;
            req_left <= req_left - LEN_W'(mem_beats);
            nxt_addr <= nxt_addr + (ADDR_W'(mem_beats) << NB_W);
        end
    end

    // Beats still owed by the granted burst.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)         pend <= '0;
        else if (mem_req && mem_gnt) pend <= mem_beats;
        else if (push)             pend <= pend - BURST_W'(1);
    end

    p_burst_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_beats != '0) && (mem_beats <= BURST_W'(MAX_BURST))))
        else $error("burst size out of range");

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !clr) |=> (mem_req && $stable(mem_addr) && $stable(mem_beats)))
        else $error("request changed before grant");
endmodule

// File: rtl/mm2s_dma.sv
// Memory-to-stream DMA read channel top. Ties the register file, burst
// sequencer and holding buffer together and produces tlast/tkeep from the
// count of emitted beats.
// Assumes: DATA_W is a multiple of 16, stream and memory words share DATA_W.
module mm2s_dma #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 14,
    parameter int MAX_BURST = 16,
    localparam int NB       = DATA_W / 8,
    localparam int NB_W     = $clog2(NB),
    localparam int BURST_W  = $clog2(MAX_BURST + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [BURST_W-1:0] mem_beats,
    input  logic               mem_gnt,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_rvalid,
    output logic [DATA_W-1:0]  m_tdata,
    output logic [NB-1:0]      m_tkeep,
    output logic               m_tlast,
    output logic               m_tvalid,
    input  logic               m_tready,
    output logic               irq_done,
    output logic               irq_err
);
    localparam int CNT_W = BURST_W;

    logic              busy, srst_q, go, hs, done_evt, push, empty;
    logic [ADDR_W-1:0] src_q;
    logic [LEN_W-1:0]  len_wr, beats_new, tot_q, out_cnt;
    logic [NB_W-1:0]   tail_q;
    logic [CNT_W-1:0]  fifo_cnt;

    assign beats_new = LEN_W'(({1'b0, len_wr} + (LEN_W+1)'(NB - 1)) >> NB_W);
    assign hs        = m_tvalid && m_tready;
    assign done_evt  = hs && m_tlast;

    mm2s_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NB_W(NB_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy),
        .done_evt(done_evt), .srst_q(srst_q), .src_q(src_q),
        .len_wr(len_wr), .go(go), .done_q(irq_done), .err_q(irq_err)
    );

    mm2s_burst #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NB_W(NB_W),
                 .MAX_BURST(MAX_BURST), .BURST_W(BURST_W), .CNT_W(CNT_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .clr(srst_q), .go(go), .src(src_q),
        .beats_total(beats_new), .fifo_cnt(fifo_cnt), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_beats(mem_beats), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .push(push)
    );

    mm2s_fifo #(.DATA_W(DATA_W), .DEPTH(MAX_BURST), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(srst_q), .push(push), .din(mem_rdata),
        .pop(hs), .dout(m_tdata), .empty(empty), .count(fifo_cnt)
    );

    // Transfer activity and emitted-beat count.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q) begin
            busy    <= 1'b0;
            out_cnt <= '0;
            tot_q   <= '0;
            tail_q  <= '0;
        end else if (go) begin
            busy    <= 1'b1;
            out_cnt <= '0;
            tot_q   <= beats_new;
            tail_q  <= len_wr[NB_W-1:0];
        end else if (hs) begin
            out_cnt <= out_cnt + LEN_W'(1);
            if (m_tlast) busy <= 1'b0;
        end
    end

    assign m_tvalid = !empty;
    assign m_tlast  = m_tvalid && (out_cnt == tot_q - LEN_W'(1));

    // Byte-valid mask: short only on a final beat with a partial tail.
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            m_tkeep[i] = !(m_tlast && (tail_q != '0)) || (i < int'(tail_q));
        end
    end

    p_stream_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready && !srst_q) |=>
            (m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast)))
        else $error("stream beat changed under backpressure");

    p_keep_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tlast) |-> (&m_tkeep))
        else $error("partial tkeep on a non-final beat");

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!m_tvalid && !mem_req))
        else $error("activity while idle");

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && !srst_q) |=> (irq_done && !busy && !m_tvalid))
        else $error("completion not reported");

    p_srst_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (!busy && !m_tvalid && !irq_done && !irq_err && !srst_q))
        else $error("soft reset left state behind");
endmodule

// File: tb/sim_mm2s_dma.sv
module sim_mm2s_dma;
    localparam int ADDR_W = 32, DATA_W = 32, LEN_W = 14, MAX_BURST = 16;
    localparam int NB = DATA_W / 8, BURST_W = $clog2(MAX_BURST + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [BURST_W-1:0] mem_beats;
    logic [DATA_W-1:0] mem_rdata = '0, m_tdata;
    logic [NB-1:0] m_tkeep;
    logic m_tlast, m_tvalid, m_tready = 1'b0, irq_done, irq_err;

    always #5 clk = ~clk;

    mm2s_dma #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_beats(mem_beats), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .m_tdata(m_tdata),
        .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .irq_done(irq_done), .irq_err(irq_err)
    );

    int total = 0, bad = 0, rmode = 0;
    bit finished = 0;

    function automatic logic [31:0] mword(input logic [31:0] a);
        return (a * 32'h0100_0193) ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Reference model state (post-edge view, updated at each negedge for the coming edge).
    logic [31:0] m_src = '0, m_exp_addr = '0;
    bit m_busy = 0, m_done = 0, m_err = 0, m_srst = 0;
    logic [31:0] q_data[$];
    logic [NB-1:0] q_keep[$];
    bit q_last[$];

    always @(negedge clk) begin
        if (!rst_n) begin
            m_src = '0; m_busy = 0; m_done = 0; m_err = 0; m_srst = 0;
            q_data.delete(); q_keep.delete(); q_last.delete();
        end else begin
            bit set_done, set_err;
            logic [31:0] l;
            set_done = 0; set_err = 0;
            chk(irq_done == m_done, "R10 irq_done", irq_done, m_done);
            chk(irq_err == m_err, "R10 irq_err", irq_err, m_err);
            if (mem_req && !m_busy) chk(0, "R3 request while idle", 1, 0);
            if (m_tvalid && m_tready) begin
                if (q_data.size() == 0) chk(0, "R9 unexpected beat", m_tdata, 0);
                else begin
                    logic [31:0] ed; logic [NB-1:0] ek; bit el;
                    ed = q_data.pop_front(); ek = q_keep.pop_front(); el = q_last.pop_front();
                    chk(m_tdata == ed, "R2 beat data", m_tdata, ed);
                    chk(m_tkeep == ek, "R8 tkeep", m_tkeep, ek);
                    chk(m_tlast == el, "R7 tlast", m_tlast, el);
                    set_done = el;
                end
            end
            if (m_srst) begin
                m_done = 0; m_err = 0; m_busy = 0; m_srst = 0;
                q_data.delete(); q_keep.delete(); q_last.delete();
            end else begin
                if (reg_we && reg_addr == 2'd3) begin
                    l = reg_wdata & ((32'd1 << LEN_W) - 1);
                    if (l != 0) begin
                        if (m_busy || m_src[1:0] != 2'b00) set_err = 1;
                        else begin
                            int nb;
                            nb = (int'(l) + NB - 1) / NB;
                            for (int i = 0; i < nb; i++) begin
                                q_data.push_back(mword(m_src + 32'(i * NB)));
                                q_keep.push_back((i == nb - 1 && (l % NB) != 0) ?
                                                 NB'((1 << (l % NB)) - 1) : {NB{1'b1}});
                                q_last.push_back(i == nb - 1);
                            end
                            m_busy = 1;
                            m_exp_addr = m_src;
                        end
                    end
                end
                m_done = set_done || (m_done && !(reg_we && reg_addr == 2'd1 && reg_wdata[1]));
                m_err  = set_err  || (m_err  && !(reg_we && reg_addr == 2'd1 && reg_wdata[2]));
                if (set_done) m_busy = 0;
            end
            if (reg_we && reg_addr == 2'd2) m_src = reg_wdata;
            if (reg_we && reg_addr == 2'd0 && reg_wdata[0]) m_srst = 1;
        end
    end

    // Memory model: grants with random delay, returns words in order with gaps.
    logic [31:0] mq[$];
    initial forever begin
        @(posedge clk); #1;
        mem_gnt = 0; mem_rvalid = 0;
        if (!rst_n) mq.delete();
        else if (mq.size() > 0) begin
            if ($urandom % 4 != 0) begin
                mem_rvalid = 1;
                mem_rdata = mword(mq.pop_front());
            end
        end else if (mem_req && ($urandom % 3 != 0)) begin
            chk(mem_beats != 0 && mem_beats <= MAX_BURST, "R6 burst size", mem_beats, MAX_BURST);
            chk(mem_addr == m_exp_addr, "R6 burst address", mem_addr, m_exp_addr);
            for (int k = 0; k < int'(mem_beats); k++) mq.push_back(mem_addr + 32'(k * NB));
            m_exp_addr = m_exp_addr + 32'(int'(mem_beats) * NB);
            mem_gnt = 1;
        end
    end

    // Stream sink readiness.
    initial forever begin
        @(posedge clk); #1;
        case (rmode)
            0: m_tready = 1;
            1: m_tready = 1'($urandom % 2);
            default: m_tready = 0;
        endcase
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!irq_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(irq_done == 1, req, irq_done, 1);
    endtask

    task automatic run(input logic [31:0] src, input logic [31:0] len, input string req);
        wr(2'd2, src);
        wr(2'd3, len);
        wait_done(req);
        rd_chk(2'd1, 32'd11, "R10 status after completion");
        wr(2'd1, 32'h2);
        rd_chk(2'd1, 32'd9, "R10 done cleared");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        report();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd_chk(2'd1, 32'd9, "R1 status after reset");
        chk(!m_tvalid && !mem_req && !irq_done && !irq_err, "R1 outputs quiet", m_tvalid, 0);

        // R2 R7 R10: 256 bytes, full keep throughout
        rmode = 0;
        run(32'h100, 32'd256, "R2 256-byte completion");
        // R8 R9: partial tail with random backpressure
        rmode = 1;
        run(32'h2000, 32'd255, "R8 255-byte completion");
        run(32'h3004, 32'd5, "R8 5-byte completion");

        // R3 zero count does nothing
        wr(2'd3, 32'd0);
        repeat (10) @(posedge clk);
        rd_chk(2'd1, 32'd9, "R3 zero count ignored");

        // R4 misaligned start
        wr(2'd2, 32'h102);
        wr(2'd3, 32'd16);
        repeat (10) @(posedge clk);
        rd_chk(2'd1, 32'd13, "R4 misaligned flags error, stays idle");
        wr(2'd1, 32'h4);
        rd_chk(2'd1, 32'd9, "R4 error cleared");

        // R5 count write while busy
        wr(2'd2, 32'h400);
        wr(2'd3, 32'd200);
        wr(2'd3, 32'd40);
        wait_done("R5 first transfer still completes");
        rd_chk(2'd1, 32'd15, "R5 error plus done");
        rd_chk(2'd3, 32'd200, "R5 count unchanged");
        wr(2'd1, 32'h6);
        rd_chk(2'd1, 32'd9, "R5 flags cleared");

        // R12 truncated count and maximum count
        rmode = 0;
        run(32'h40, 32'h0000_4008, "R12 truncated count completes");
        rd_chk(2'd3, 32'd8, "R12 count readback truncated");
        run(32'h0, 32'd16383, "R12 maximum count completes");

        // R11 soft reset with data held in the buffer
        rmode = 2;
        wr(2'd2, 32'h800);
        wr(2'd3, 32'd128);
        repeat (80) @(posedge clk);
        chk(m_tvalid == 1, "R9 beat waits under backpressure", m_tvalid, 1);
        wr(2'd0, 32'h1);
        reg_addr = 2'd1;
        @(negedge clk);
        chk(reg_rdata == 32'd0, "R11 reset-finished bit low", reg_rdata, 0);
        rd_chk(2'd1, 32'd9, "R11 idle after soft reset");
        chk(m_tvalid == 0, "R11 stream empty", m_tvalid, 0);
        rmode = 0;
        run(32'h44, 32'd12, "R11 transfer after soft reset");

        repeat (5) @(posedge clk);
        chk(q_data.size() == 0, "R9 all beats delivered", q_data.size(), 0);
        report();
    end
endmodule